// File: doc/BRIEF.md
# Saturating multiply-accumulate unit

This block multiplies two signed 16-bit operands and adds the product into a 42-bit accumulator. One mode input chooses how each sum is kept. In clamping mode the sum is pinned to the signed 32-bit range, and a sticky flag records that this happened. In wrapping mode the sum uses all 42 bits and rolls over modulo 2^42.

Besides the multiply-accumulate strobe, the block has four other controls. A clear strobe zeroes the accumulator. Two load strobes write a 32-bit data word into the low or the high part. A select input returns either part on a combinational read port. All strobes last one cycle, and the accumulator changes on the rising edge that follows.

A small decoder turns the strobes into one command per cycle: `CMD_IDLE`, `CMD_LOAD`, `CMD_CLEAR`, `CMD_MAC` or `CMD_CLRMAC`. Loads have the highest priority, so a load in the same cycle as clear or multiply-accumulate suppresses both. Clear together with multiply-accumulate gives `CMD_CLRMAC`.

The overflow flag is a two-state machine with the states `FLAG_CLEAN` and `FLAG_CLAMPED`:
- It moves from `FLAG_CLEAN` to `FLAG_CLAMPED` when a clamp occurs.
- It returns from `FLAG_CLAMPED` to `FLAG_CLEAN` on a clear command or a load command.
- In every other cycle it holds its state.

Top module: `sat_mac`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the whole accumulator to zero and the flag to 0.
- R2: On a multiply-accumulate strobe, the signed product op_a*op_b is added to the accumulator. In wrapping mode (sat_mode=0) this never sets the flag.
- R3: In wrapping mode the 42-bit sum rolls over modulo 2^42. For example, 2^41-1 plus 1 gives -2^41.
- R4: In clamping mode (sat_mode=1), the sum is computed exactly and compared with the signed 32-bit range. Above the range the result is 0x7FFFFFFF; below it the result is 0x80000000. The 32-bit result is sign-extended into bits 41:32.
- R5: A clamp sets the overflow flag. The flag stays set through later multiply-accumulates until a clear command or a load command.
- R6: A clear strobe alone zeroes the accumulator and drops the flag.
- R7: Clear and multiply-accumulate in the same cycle leave the product alone in the accumulator and drop the flag.
- R8: Loads work as follows:
  - ld_lo writes ld_data into bits 31:0.
  - ld_hi writes ld_data[9:0] into bits 41:32.
  - Both together write both parts.
  - Any load drops the flag.
  - A load suppresses clear and multiply-accumulate strobes in the same cycle.
- R9: With rd_sel=0, rd_data shows bits 31:0. With rd_sel=1, it shows bits 41:32 sign-extended from bit 41 to 32 bits.
- R10: A cycle with no strobe leaves the accumulator unchanged, whatever sat_mode does. The mode only affects later sums.
- R11: In clamping mode, an accumulator loaded beyond the 32-bit range is clamped by the next multiply-accumulate, even when the product is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sat_mode | input | 1 | 1 = clamp to signed 32-bit range, 0 = wrap over 42 bits |
| mac_en | input | 1 | Multiply-accumulate strobe |
| clr | input | 1 | Clear strobe |
| ld_hi | input | 1 | Load strobe for bits 41:32 (from ld_data[9:0]) |
| ld_lo | input | 1 | Load strobe for bits 31:0 |
| op_a | input | 16 | Signed multiplicand |
| op_b | input | 16 | Signed multiplier |
| ld_data | input | 32 | Load data word |
| rd_sel | input | 1 | Read select: 0 low part, 1 high part |
| rd_data | output | 32 | Selected accumulator part |
| ovf_sticky | output | 1 | Sticky clamp flag |

## Verification
The bench builds the unit with its default parameters: 16-bit operands, a 42-bit accumulator and a 32-bit clamp range. These leave a 10-bit high field, which the bench drives to both of its extremes. They also make the largest product 2^30, so two such products cross into bit 31 without clamping in wrapping mode. The same setting makes the boundary cases reachable in a few strobes:
- the 2^42 rollover;
- clamping in both directions;
- clamping of a loaded value that lies outside the 32-bit range.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;

    // One command per cycle, decoded from the strobes.
    typedef enum logic [2:0] {
        CMD_IDLE,
        CMD_LOAD,
        CMD_CLEAR,
        CMD_MAC,
        CMD_CLRMAC
    } cmd_e;

    // Sticky clamp flag states.
    typedef enum logic {
        FLAG_CLEAN,
        FLAG_CLAMPED
    } flag_e;

endpackage

// File: rtl/mac_cmd_dec.sv
module mac_cmd_dec
    import sat_mac_pkg::*;
(
    input  logic mac_en,
    input  logic clr,
    input  logic ld_hi,
    input  logic ld_lo,
    output cmd_e cmd
);

    // Loads win over everything. Clear together with MAC gives the
    // combined command.
    always_comb begin
        if (ld_hi || ld_lo) begin
            cmd = CMD_LOAD;
        end else if (clr && mac_en) begin
            cmd = CMD_CLRMAC;
        end else if (clr) begin
            cmd = CMD_CLEAR;
        end else if (mac_en) begin
            cmd = CMD_MAC;
        end else begin
            cmd = CMD_IDLE;
        end
    end

endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int OP_W  = 16,
    parameter int ACC_W = 42
) (
    input  logic signed [OP_W-1:0]  op_a,
    input  logic signed [OP_W-1:0]  op_b,
    output logic        [ACC_W-1:0] prod_ext
);

    localparam int PROD_W = 2 * OP_W;
    localparam int EXT_W  = ACC_W - PROD_W;

    logic signed [PROD_W-1:0] prod;

    // Signed product, sign-extended to the accumulator width.
    always_comb begin
        prod     = op_a * op_b;
        prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};
    end

endmodule

// File: rtl/mac_next.sv
module mac_next #(
    parameter int ACC_W = 42,
    parameter int SAT_W = 32
) (
    input  logic [ACC_W-1:0] acc_q,
    input  logic [ACC_W-1:0] prod_ext,
    input  logic             base_zero,
    input  logic             sat_mode,
    output logic [ACC_W-1:0] acc_nxt,
    output logic             clamp
);

    // Bits from the guard bit down to the clamp sign bit.
    localparam int UP_W = ACC_W - SAT_W + 2;

    localparam logic [ACC_W-1:0] SAT_MAX =
        {{(ACC_W-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] SAT_MIN =
        {{(ACC_W-SAT_W+1){1'b1}}, {(SAT_W-1){1'b0}}};

    logic [ACC_W:0]  base_w;
    logic [ACC_W:0]  prod_w;
    logic [ACC_W:0]  sum_w;
    logic [UP_W-1:0] upper;
    logic            in_range;

    // Add with one guard bit, so that clamping sees the exact sum even
    // when a loaded value sits near the 42-bit limits.
    always_comb begin
        base_w   = base_zero ? '0 : {acc_q[ACC_W-1], acc_q};
        prod_w   = {prod_ext[ACC_W-1], prod_ext};
        sum_w    = base_w + prod_w;
        upper    = sum_w[ACC_W:SAT_W-1];
        in_range = (upper == '0) || (upper == '1);
    end

    always_comb begin
        acc_nxt = sum_w[ACC_W-1:0];
        clamp   = 1'b0;
        if (sat_mode && !in_range) begin
            clamp   = 1'b1;
            acc_nxt = sum_w[ACC_W] ? SAT_MIN : SAT_MAX;
        end
    end

endmodule

// File: rtl/mac_flag_fsm.sv
module mac_flag_fsm
    import sat_mac_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clamp_evt,
    input  logic clr_evt,
    input  logic ld_evt,
    output logic flag
);

    flag_e state_q;
    flag_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FLAG_CLEAN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAN: begin
                if (clamp_evt && !clr_evt && !ld_evt) begin
                    state_d = FLAG_CLAMPED;
                end
            end
            FLAG_CLAMPED: begin
                if (clr_evt || ld_evt) begin
                    state_d = FLAG_CLEAN;
                end
            end
            default: state_d = FLAG_CLEAN;
        endcase
    end

    // Output
    always_comb begin
        flag = (state_q == FLAG_CLAMPED);
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        (clamp_evt && !clr_evt && !ld_evt) |=> (state_q == FLAG_CLAMPED)); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (state_q == FLAG_CLAMPED && !clr_evt && !ld_evt) |=> (state_q == FLAG_CLAMPED)); // R5
    AST_FLAG_DROP: assert property (@(posedge clk) disable iff (rst)
        (clr_evt || ld_evt) |=> (state_q == FLAG_CLEAN)); // R6

endmodule

// File: rtl/sat_mac.sv
module sat_mac
    import sat_mac_pkg::*;
#(
    parameter int OP_W  = 16,
    parameter int ACC_W = 42,
    parameter int SAT_W = 32,
    parameter int REG_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sat_mode,
    input  logic                   mac_en,
    input  logic                   clr,
    input  logic                   ld_hi,
    input  logic                   ld_lo,
    input  logic signed [OP_W-1:0] op_a,
    input  logic signed [OP_W-1:0] op_b,
    input  logic [REG_W-1:0]       ld_data,
    input  logic                   rd_sel,
    output logic [REG_W-1:0]       rd_data,
    output logic                   ovf_sticky
);

    localparam int HI_W  = ACC_W - REG_W;
    localparam int EXT_W = REG_W - HI_W;

    cmd_e             cmd;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] prod_ext;
    logic [ACC_W-1:0] acc_nxt;
    logic             clamp;
    logic             take_mac;
    logic             base_zero;
    logic             clr_evt;
    logic             ld_evt;

    mac_cmd_dec u_dec (
        .mac_en (mac_en),
        .clr    (clr),
        .ld_hi  (ld_hi),
        .ld_lo  (ld_lo),
        .cmd    (cmd)
    );

    mac_mult #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mult (
        .op_a     (op_a),
        .op_b     (op_b),
        .prod_ext (prod_ext)
    );

    always_comb begin
        take_mac  = (cmd == CMD_MAC) || (cmd == CMD_CLRMAC);
        base_zero = (cmd == CMD_CLRMAC);
        clr_evt   = (cmd == CMD_CLEAR) || (cmd == CMD_CLRMAC);
        ld_evt    = (cmd == CMD_LOAD);
    end

    mac_next #(.ACC_W(ACC_W), .SAT_W(SAT_W)) u_next (
        .acc_q     (acc_q),
        .prod_ext  (prod_ext),
        .base_zero (base_zero),
        .sat_mode  (sat_mode),
        .acc_nxt   (acc_nxt),
        .clamp     (clamp)
    );

    mac_flag_fsm u_flag (
        .clk       (clk),
        .rst       (rst),
        .clamp_evt (take_mac && clamp),
        .clr_evt   (clr_evt),
        .ld_evt    (ld_evt),
        .flag      (ovf_sticky)
    );

    // Accumulator register
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            unique case (cmd)
                CMD_LOAD: begin
                    if (ld_hi) acc_q[ACC_W-1:REG_W] <= ld_data[HI_W-1:0];
                    if (ld_lo) acc_q[REG_W-1:0]     <= ld_data;
                end
                CMD_CLEAR:            acc_q <= '0;
                CMD_MAC, CMD_CLRMAC:  acc_q <= acc_nxt;
                default:              acc_q <= acc_q;
            endcase
        end
    end

    // Read port
    always_comb begin
        if (rd_sel) begin
            rd_data = {{EXT_W{acc_q[ACC_W-1]}}, acc_q[ACC_W-1:REG_W]};
        end else begin
            rd_data = acc_q[REG_W-1:0];
        end
    end

    AST_SAT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (take_mac && sat_mode) |=>
            ((acc_q[ACC_W-1:SAT_W-1] == '0) || (acc_q[ACC_W-1:SAT_W-1] == '1))); // R4
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_CLEAR) |=> (acc_q == '0)); // R6
    AST_LOAD_LO: assert property (@(posedge clk) disable iff (rst)
        ld_lo |=> (acc_q[REG_W-1:0] == $past(ld_data))); // R8
    AST_LOAD_KEEP_HI: assert property (@(posedge clk) disable iff (rst)
        (ld_lo && !ld_hi) |=> (acc_q[ACC_W-1:REG_W] == $past(acc_q[ACC_W-1:REG_W]))); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!mac_en && !clr && !ld_hi && !ld_lo) |=> $stable(acc_q)); // R10

endmodule

// File: tb/tb_sat_mac.sv
module tb_sat_mac;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sat_mode = 1'b0;
    logic        mac_en = 1'b0;
    logic        clr = 1'b0;
    logic        ld_hi = 1'b0;
    logic        ld_lo = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic [31:0] ld_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        ovf_sticky;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sat_mac dut (
        .clk        (clk),
        .rst        (rst),
        .sat_mode   (sat_mode),
        .mac_en     (mac_en),
        .clr        (clr),
        .ld_hi      (ld_hi),
        .ld_lo      (ld_lo),
        .op_a       (op_a),
        .op_b       (op_b),
        .ld_data    (ld_data),
        .rd_sel     (rd_sel),
        .rd_data    (rd_data),
        .ovf_sticky (ovf_sticky)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // One-cycle strobe, driven on the falling edge; returns one cycle later.
    task automatic pulse(bit m, bit c, bit lh, bit ll,
                         logic [15:0] a, logic [15:0] b, logic [31:0] d);
        @(negedge clk);
        mac_en = m; clr = c; ld_hi = lh; ld_lo = ll;
        op_a = a; op_b = b; ld_data = d;
        @(negedge clk);
        mac_en = 0; clr = 0; ld_hi = 0; ld_lo = 0;
    endtask

    task automatic expect_acc(string tag, logic [31:0] hi, logic [31:0] lo, bit f);
        rd_sel = 1'b0; #1;
        chk({tag, " low"}, rd_data, lo);
        rd_sel = 1'b1; #1;
        chk({tag, " high"}, rd_data, hi);
        chk({tag, " flag"}, {31'd0, ovf_sticky}, {31'd0, f});
        rd_sel = 1'b0;
    endtask

    task automatic test_reset();
        expect_acc("R1 reset", 32'h0, 32'h0, 1'b0);
    endtask

    task automatic test_wrap_accumulate();
        sat_mode = 1'b0;
        pulse(1, 0, 0, 0, 16'd3, 16'hFFFB, '0);            // 3 * -5
        expect_acc("R2 neg product", 32'hFFFFFFFF, 32'hFFFFFFF1, 1'b0);
        pulse(1, 0, 0, 0, 16'd100, 16'd200, '0);           // + 20000
        expect_acc("R2 accumulate", 32'h0, 32'h00004E11, 1'b0);
        pulse(0, 1, 0, 0, '0, '0, '0);
        pulse(1, 0, 0, 0, 16'h8000, 16'h8000, '0);         // 2^30
        pulse(1, 0, 0, 0, 16'h8000, 16'h8000, '0);         // 2^31, no clamp
        expect_acc("R2 past 32 bits wrap mode", 32'h0, 32'h80000000, 1'b0);
    endtask

    task automatic test_wrap_42();
        sat_mode = 1'b0;
        pulse(0, 0, 1, 0, '0, '0, 32'h000001FF);
        pulse(0, 0, 0, 1, '0, '0, 32'hFFFFFFFF);
        expect_acc("R3 loaded max", 32'h000001FF, 32'hFFFFFFFF, 1'b0);
        pulse(1, 0, 0, 0, 16'd1, 16'd1, '0);
        expect_acc("R3 rollover", 32'hFFFFFE00, 32'h0, 1'b0);
    endtask

    task automatic test_sat_pos();
        pulse(0, 1, 0, 0, '0, '0, '0);
        pulse(0, 0, 0, 1, '0, '0, 32'h7FFFFFF0);
        sat_mode = 1'b1;
        pulse(1, 0, 0, 0, 16'd4, 16'd4, '0);
        expect_acc("R4 clamp high", 32'h0, 32'h7FFFFFFF, 1'b1);
        pulse(1, 0, 0, 0, 16'd1, 16'hFFFF, '0);
        expect_acc("R5 flag sticky", 32'h0, 32'h7FFFFFFE, 1'b1);
    endtask

    task automatic test_sat_neg();
        sat_mode = 1'b1;
        pulse(0, 0, 1, 0, '0, '0, 32'h000003FF);
        expect_acc("R8 load drops flag", 32'hFFFFFFFF, 32'h7FFFFFFE, 1'b0);
        pulse(0, 0, 0, 1, '0, '0, 32'h80000005);
        pulse(1, 0, 0, 0, 16'hFFFD, 16'd4, '0);            // -12
        expect_acc("R4 clamp low", 32'hFFFFFFFF, 32'h80000000, 1'b1);
    endtask

    task automatic test_sat_wide();
        sat_mode = 1'b1;
        pulse(0, 0, 1, 0, '0, '0, 32'h00000005);
        pulse(0, 0, 0, 1, '0, '0, 32'h0);
        expect_acc("R11 loaded wide", 32'h00000005, 32'h0, 1'b0);
        pulse(1, 0, 0, 0, 16'd0, 16'd0, '0);
        expect_acc("R11 clamp loaded", 32'h0, 32'h7FFFFFFF, 1'b1);
    endtask

    task automatic test_clear();
        pulse(0, 1, 0, 0, '0, '0, '0);
        expect_acc("R6 clear", 32'h0, 32'h0, 1'b0);
    endtask

    task automatic test_clr_mac();
        sat_mode = 1'b1;
        pulse(0, 0, 0, 1, '0, '0, 32'h7FFFFFFF);
        pulse(1, 0, 0, 0, 16'd1, 16'd1, '0);
        expect_acc("R7 setup clamp", 32'h0, 32'h7FFFFFFF, 1'b1);
        pulse(1, 1, 0, 0, 16'd7, 16'hFFF7, '0);            // -63
        expect_acc("R7 clear with mac", 32'hFFFFFFFF, 32'hFFFFFFC1, 1'b0);
    endtask

    task automatic test_load_priority();
        sat_mode = 1'b0;
        pulse(1, 0, 0, 1, 16'd1000, 16'd1000, 32'h12345678);
        expect_acc("R8 load beats mac", 32'hFFFFFFFF, 32'h12345678, 1'b0);
        pulse(0, 0, 1, 1, '0, '0, 32'h00000155);
        expect_acc("R8 load both", 32'h00000155, 32'h00000155, 1'b0);
        pulse(0, 1, 1, 0, '0, '0, 32'h000002AA);
        expect_acc("R9 high sign-extend", 32'hFFFFFEAA, 32'h00000155, 1'b0);
        pulse(0, 1, 0, 0, '0, '0, '0);
        pulse(0, 0, 0, 1, '0, '0, 32'h7FFFFFFF);
        sat_mode = 1'b1;
        pulse(1, 0, 0, 0, 16'd1, 16'd1, '0);
        expect_acc("R8 setup clamp", 32'h0, 32'h7FFFFFFF, 1'b1);
        pulse(0, 0, 0, 1, '0, '0, 32'h00000005);
        expect_acc("R8 low load drops flag", 32'h0, 32'h00000005, 1'b0);
    endtask

    task automatic test_mode_idle();
        pulse(0, 0, 1, 0, '0, '0, 32'h00000155);
        expect_acc("R9 high positive", 32'h00000155, 32'h00000005, 1'b0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            sat_mode = ~sat_mode;
        end
        @(negedge clk);
        expect_acc("R10 idle mode toggle", 32'h00000155, 32'h00000005, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_wrap_accumulate();
        test_wrap_42();
        test_sat_pos();
        test_sat_neg();
        test_sat_wide();
        test_clear();
        test_clr_mac();
        test_load_priority();
        test_mode_idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule